// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Port with Sticky Error Flags

This block is a full-duplex asynchronous serial port. It sends and receives frames in one of five layouts, chosen by a format code. The layouts differ in the number of data bits and in whether a parity bit follows the data. A free-running tick at sixteen times the bit rate paces both directions. The block does not generate that tick.

The transmitter accepts a word through a write strobe and shifts it out least significant bit first. It pulses an interrupt in the cycle in which the line switches to the stop level. The receiver synchronises the serial input and rejects start pulses that are shorter than half a bit. It samples each bit at its middle and stores the completed word, right-aligned, in a buffer. It pulses a receive interrupt at a point that depends on the format: the middle of the last frame bit for nine-bit frames, and the middle of the stop bit for all others.

Parity, framing and overrun errors are held in sticky flags. A flag read strobe clears all three flags. A set that arrives in the same cycle as the read wins.

Top module: `smu_uart`

## Requirements
- R1: Format codes are 0 = 7 data bits, 1 = 7 data + parity, 2 = 8 data bits, 3 = 8 data + parity, 4 = 9 data bits (codes 5..7 act as 2). The received word appears right-aligned on `rx_data_o`, with unused upper bits zero.
- R2: The transmit line idles high. A frame is a low start bit, then the data bits LSB first, then the parity bit if the format has one, then a high stop bit. Each bit lasts 16 ticks. A write while busy is ignored.
- R3: `par_odd_i` = 0 selects even parity (data plus parity bit hold an even count of ones). `par_odd_i` = 1 selects odd parity. The setting applies to both directions.
- R4: For formats 3 and 4, `rx_irq_o` pulses for one cycle at the middle of the last (ninth) frame bit.
- R5: For formats 0, 1 and 2, `rx_irq_o` pulses at the middle of the stop bit.
- R6: `tx_irq_o` pulses for one cycle in the cycle in which `txd_o` turns from the last frame bit to the stop level, in every format.
- R7: A low level on `rxd_i` that has ended by the mid-bit sample (sample 8 of 16) is dropped: no word and no interrupt.
- R8: The stop bit is sampled at ticks 7, 8 and 9 of 16. If at least two of the three samples are low, the framing flag `ferr_o` sets at the middle of the stop bit.
- R9: In parity formats, a received parity bit that disagrees with the parity computed over the buffered data sets `perr_o`.
- R10: If a word completes while the previous word is still unread (no `rx_rd_i` since it was loaded), `oerr_o` sets at the middle of the stop bit and the new word replaces the old one.
- R11: `flag_rd_i` clears all three flags. A flag whose set condition occurs in the same cycle as the read stays set.
- R12: Out of reset, `txd_o` is high, `tx_busy_o` is low, both interrupts are low, all flags are clear and `rx_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| fmt_i | input | 3 | Frame format code |
| par_odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| tx_data_i | input | 9 | Word to transmit, right-aligned |
| tx_wr_i | input | 1 | Transmit write strobe |
| txd_o | output | 1 | Serial output |
| tx_busy_o | output | 1 | Transmitter is sending a frame |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rxd_i | input | 1 | Serial input |
| rx_data_o | output | 9 | Receive buffer |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| flag_rd_i | input | 1 | Error flag read strobe, clears the flags |
| perr_o | output | 1 | Sticky parity error |
| ferr_o | output | 1 | Sticky framing error |
| oerr_o | output | 1 | Sticky overrun error |

## Verification
The interaction of interest is a read of the error flags that falls in the same clock cycle as the stop-bit vote setting the framing flag. The bench holds `flag_rd_i` high for the whole of an 8-bit frame whose stop bit is driven low. The flag must be visible in the cycle of the receive interrupt, when set and read coincide, and must be cleared one cycle later, when only the read remains. A second case runs a buffer read against a word load: an overrun must appear only when no read falls between two completed words.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int WMAX = 9;
  localparam int IW   = 4;

  localparam logic [2:0] FMT_D7  = 3'd0;
  localparam logic [2:0] FMT_D7P = 3'd1;
  localparam logic [2:0] FMT_D8P = 3'd3;
  localparam logic [2:0] FMT_D9  = 3'd4;

  function automatic logic [IW-1:0] data_len(logic [2:0] f);
    case (f)
      FMT_D7, FMT_D7P: return 4'd7;
      FMT_D9:          return 4'd9;
      default:         return 4'd8;
    endcase
  endfunction

  function automatic logic has_par(logic [2:0] f);
    return (f == FMT_D7P) || (f == FMT_D8P);
  endfunction

  function automatic logic [IW-1:0] frame_len(logic [2:0] f);
    return data_len(f) + {3'b000, has_par(f)};
  endfunction

  // nine-bit frames signal the word at the last bit, not at the stop bit
  function automatic logic early_irq(logic [2:0] f);
    return frame_len(f) == 4'd9;
  endfunction

  function automatic logic [WMAX-1:0] data_mask(logic [2:0] f);
    case (data_len(f))
      4'd7:    return 9'h07f;
      4'd9:    return 9'h1ff;
      default: return 9'h0ff;
    endcase
  endfunction
endpackage

// File: rtl/smu_flag.sv
module smu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~rd_i);
  end

  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R11
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !set_i) |=> !q_o);
endmodule

// File: rtl/smu_tx.sv
module smu_tx
  import smu_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [2:0]      fmt_i,
  input  logic            par_odd_i,
  input  logic [WMAX-1:0] data_i,
  input  logic            wr_i,
  output logic            txd_o,
  output logic            busy_o,
  output logic            irq_o
);
  localparam int CW = $clog2(OVS);

  typedef enum logic [1:0] {T_IDLE, T_START, T_BITS, T_STOP} tst_e;

  tst_e            st_q;
  logic [CW-1:0]   cnt_q;
  logic [IW-1:0]   idx_q, last_q;
  logic [WMAX:0]   fr_q, fr_d;
  logic [WMAX-1:0] dm;

  always_comb begin
    dm   = data_i & data_mask(fmt_i);
    fr_d = {1'b0, dm};
    if (has_par(fmt_i)) fr_d[data_len(fmt_i)] = (^dm) ^ par_odd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      fr_q   <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (st_q == T_IDLE) begin
        if (wr_i) begin
          st_q   <= T_START;
          cnt_q  <= '0;
          fr_q   <= fr_d;
          last_q <= frame_len(fmt_i) - 4'd1;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(OVS-1)) begin
          case (st_q)
            T_START: begin
              st_q  <= T_BITS;
              idx_q <= '0;
            end
            T_BITS: begin
              if (idx_q == last_q) begin
                st_q  <= T_STOP;
                irq_o <= 1'b1;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            default: st_q <= T_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st_q)
      T_START: txd_o = 1'b0;
      T_BITS:  txd_o = fr_q[idx_q];
      default: txd_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != T_IDLE);

  // R6
  stop_on_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (busy_o && txd_o));
  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
endmodule

// File: rtl/smu_rx.sv
module smu_rx
  import smu_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [2:0]      fmt_i,
  input  logic            par_odd_i,
  input  logic            rxd_i,
  input  logic            rd_i,
  output logic [WMAX-1:0] data_o,
  output logic            irq_o,
  output logic            perr_set_o,
  output logic            ferr_set_o,
  output logic            oerr_set_o
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rst_e;

  rst_e            st_q;
  logic [1:0]      sync_q;
  logic [CW-1:0]   cnt_q;
  logic [IW-1:0]   idx_q;
  logic [WMAX:0]   sh_q, word, sel_word;
  logic [1:0]      vote_q;
  logic            unread_q, opend_q;
  logic            rx_s, early, last_bit, samp, stop_ctr, ld, fin, maj, unread_eff, perr_now;
  logic [WMAX-1:0] dat;

  assign rx_s     = sync_q[1];
  assign early    = early_irq(fmt_i);
  assign last_bit = (idx_q == frame_len(fmt_i) - 4'd1);
  assign samp     = tick_i && (cnt_q == CW'(MID-1));
  assign stop_ctr = tick_i && (cnt_q == CW'(MID));

  always_comb begin
    word         = sh_q;
    word[idx_q]  = rx_s;  // bit sampled this cycle joins the word early
    sel_word     = (st_q == R_DATA) ? word : sh_q;
    dat          = sel_word[WMAX-1:0] & data_mask(fmt_i);
    perr_now     = has_par(fmt_i) && (sel_word[data_len(fmt_i)] != ((^dat) ^ par_odd_i));
    ld           = ((st_q == R_DATA) && samp && last_bit && early) ||
                   ((st_q == R_STOP) && stop_ctr && !early);
    fin          = (st_q == R_STOP) && stop_ctr;
    maj          = (vote_q[0] & vote_q[1]) | (vote_q[0] & rx_s) | (vote_q[1] & rx_s);
    unread_eff   = unread_q & ~rd_i;
  end

  assign perr_set_o = ld && perr_now;
  assign ferr_set_o = fin && !maj;
  assign oerr_set_o = fin && (early ? opend_q : unread_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 2'b11;
      st_q     <= R_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      vote_q   <= 2'b11;
      unread_q <= 1'b0;
      opend_q  <= 1'b0;
      data_o   <= '0;
      irq_o    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      irq_o  <= 1'b0;
      if (rd_i) unread_q <= 1'b0;
      if (ld) begin
        data_o   <= dat;
        unread_q <= 1'b1;
        irq_o    <= 1'b1;
        if (early) opend_q <= unread_eff;
      end
      if (st_q == R_IDLE) begin
        if (tick_i && !rx_s) begin
          st_q  <= R_START;
          cnt_q <= '0;
          sh_q  <= '0;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        case (st_q)
          R_START: begin
            if (cnt_q == CW'(MID-1) && rx_s) st_q <= R_IDLE;
            else if (cnt_q == CW'(OVS-1)) begin
              st_q  <= R_DATA;
              idx_q <= '0;
            end
          end
          R_DATA: begin
            if (cnt_q == CW'(MID-1)) sh_q[idx_q] <= rx_s;
            if (cnt_q == CW'(OVS-1)) begin
              if (last_bit) st_q <= R_STOP;
              else          idx_q <= idx_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q == CW'(MID-2)) vote_q[0] <= rx_s;
            if (cnt_q == CW'(MID-1)) vote_q[1] <= rx_s;
            if (cnt_q == CW'(MID))   st_q <= R_IDLE;
          end
        endcase
      end
    end
  end

  // R4
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R1
  narrow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (fmt_i == FMT_D7 || fmt_i == FMT_D7P)) |-> (data_o[WMAX-1:WMAX-2] == 2'b00));
  // R10
  ovr_needs_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_set_o |-> unread_q);
endmodule

// File: rtl/smu_uart.sv
module smu_uart
  import smu_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] fmt_i,
  input  logic       par_odd_i,
  input  logic [8:0] tx_data_i,
  input  logic       tx_wr_i,
  output logic       txd_o,
  output logic       tx_busy_o,
  output logic       tx_irq_o,
  input  logic       rxd_i,
  output logic [8:0] rx_data_o,
  input  logic       rx_rd_i,
  output logic       rx_irq_o,
  input  logic       flag_rd_i,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       oerr_o
);
  localparam int NF = 3;

  logic          pset, fset, oset;
  logic [NF-1:0] set_w, q_w;

  smu_tx #(.OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i, .fmt_i, .par_odd_i,
    .data_i(tx_data_i), .wr_i(tx_wr_i),
    .txd_o, .busy_o(tx_busy_o), .irq_o(tx_irq_o)
  );

  smu_rx #(.OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i, .fmt_i, .par_odd_i,
    .rxd_i, .rd_i(rx_rd_i), .data_o(rx_data_o), .irq_o(rx_irq_o),
    .perr_set_o(pset), .ferr_set_o(fset), .oerr_set_o(oset)
  );

  assign set_w = {oset, fset, pset};

  for (genvar g = 0; g < NF; g++) begin : g_flag
    smu_flag u_flag (
      .clk_i, .rst_ni, .set_i(set_w[g]), .rd_i(flag_rd_i), .q_o(q_w[g])
    );
  end

  assign perr_o = q_w[0];
  assign ferr_o = q_w[1];
  assign oerr_o = q_w[2];
endmodule

// File: tb/smu_uart_test.sv
module smu_uart_test;
  logic       clk = 0, rst_n = 0, tick = 0;
  logic [2:0] fmt = 3'd2;
  logic       odd = 0, tx_wr = 0, rxd = 1, rx_rd = 0, flag_rd = 0;
  logic [8:0] tx_word = '0;
  wire        txd, tx_busy, tx_irq, rx_irq, perr, ferr, oerr;
  wire  [8:0] rx_data;

  int checks = 0, errors = 0, cyc = 0;
  int rx_irq_cnt = 0, rx_irq_cyc = 0, tx_irq_cnt = 0, tx_irq_cyc = 0;
  logic txd_at_irq = 0, ferr_at_irq = 0;

  smu_uart uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fmt_i(fmt), .par_odd_i(odd),
    .tx_data_i(tx_word), .tx_wr_i(tx_wr), .txd_o(txd), .tx_busy_o(tx_busy),
    .tx_irq_o(tx_irq), .rxd_i(rxd), .rx_data_o(rx_data), .rx_rd_i(rx_rd),
    .rx_irq_o(rx_irq), .flag_rd_i(flag_rd), .perr_o(perr), .ferr_o(ferr), .oerr_o(oerr)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  always @(negedge clk) begin
    cyc++;
    if (rx_irq) begin rx_irq_cnt++; rx_irq_cyc = cyc; ferr_at_irq = ferr; end
    if (tx_irq) begin tx_irq_cnt++; tx_irq_cyc = cyc; txd_at_irq = txd; end
  end

  function automatic int dlen(logic [2:0] f);
    return (f == 0 || f == 1) ? 7 : (f == 4) ? 9 : 8;
  endfunction
  function automatic logic hpar(logic [2:0] f);
    return f == 1 || f == 3;
  endfunction
  function automatic logic [8:0] msk(logic [2:0] f);
    return 9'h1ff >> (9 - dlen(f));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int v, int lo, int hi);
    checks++;
    if (v < lo || v > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, v, lo, hi);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); rx_rd = 1; flag_rd = 1;
    @(negedge clk); rx_rd = 0; flag_rd = 0;
  endtask

  task automatic rx_frame(logic [2:0] f, logic [8:0] d, logic o, logic flip,
                          logic stop_low, output int t0);
    logic [8:0] m = d & msk(f);
    @(negedge clk); rxd = 0; t0 = cyc;
    repeat (32) @(negedge clk);
    for (int i = 0; i < dlen(f); i++) begin rxd = m[i]; repeat (32) @(negedge clk); end
    if (hpar(f)) begin rxd = (^m) ^ o ^ flip; repeat (32) @(negedge clk); end
    if (stop_low) begin
      rxd = 0; repeat (24) @(negedge clk);
      rxd = 1; repeat (8) @(negedge clk);
    end else begin
      rxd = 1; repeat (32) @(negedge clk);
    end
    rxd = 1; repeat (32) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 txd", txd, 1);
    chk("R12 busy", tx_busy, 0);
    chk("R12 irqs", {tx_irq, rx_irq}, 0);
    chk("R12 flags", {perr, ferr, oerr}, 0);
    chk("R12 rx_data", rx_data, 0);
  endtask

  task automatic t_tx(logic [2:0] f, logic [8:0] d, logic o);
    logic [8:0] m = d & msk(f);
    int n0 = tx_irq_cnt, fall, nb;
    nb = dlen(f) + int'(hpar(f));
    fmt = f; odd = o;
    @(negedge clk); tx_word = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    for (int i = 0; i < 8 && txd; i++) @(negedge clk);
    fall = cyc;
    repeat (15) @(negedge clk);
    chk("R2 start bit", txd, 0);
    tx_word = ~d; tx_wr = 1;  // must be ignored while busy
    @(negedge clk); tx_wr = 0;
    repeat (31) @(negedge clk);
    for (int i = 0; i < dlen(f); i++) begin
      chk("R2 data bit", txd, m[i]);
      repeat (32) @(negedge clk);
    end
    if (hpar(f)) begin
      chk("R3 parity bit", txd, (^m) ^ o);
      repeat (32) @(negedge clk);
    end
    chk("R2 stop bit", txd, 1);
    repeat (40) @(negedge clk);
    chk("R2 write while busy ignored", {tx_busy, txd}, 2'b01);
    chk("R6 one tx irq", tx_irq_cnt - n0, 1);
    chk("R6 txd at irq", txd_at_irq, 1);
    chk_rng("R6 tx irq position", tx_irq_cyc - fall, 32 * (nb + 1) - 3, 32 * (nb + 1) + 3);
  endtask

  task automatic t_rx(logic [2:0] f, logic [8:0] d, logic o, logic flip, logic sl);
    int t0, n0 = rx_irq_cnt, nb, k;
    logic early;
    nb = dlen(f) + int'(hpar(f));
    early = (nb == 9);
    k = early ? nb : nb + 1;
    fmt = f; odd = o;
    rx_frame(f, d, o, flip, sl, t0);
    chk("R1 word", rx_data, d & msk(f));
    chk("R4/R5 one rx irq", rx_irq_cnt - n0, 1);
    if (early) chk_rng("R4 irq at last bit", rx_irq_cyc - t0, 32 * k + 10, 32 * k + 26);
    else       chk_rng("R5 irq at stop bit", rx_irq_cyc - t0, 32 * k + 10, 32 * k + 26);
    chk("R9 parity flag", perr, flip & hpar(f));
    chk("R8 framing flag", ferr, sl);
    chk("R10 no overrun", oerr, 0);
    clear_all();
    chk("R11 flags cleared", {perr, ferr, oerr}, 0);
  endtask

  task automatic t_false_start();
    int n0 = rx_irq_cnt;
    logic [8:0] prev = rx_data;
    @(negedge clk); rxd = 0;
    repeat (10) @(negedge clk);
    rxd = 1;
    repeat (80) @(negedge clk);
    chk("R7 short low no irq", rx_irq_cnt - n0, 0);
    chk("R7 buffer untouched", rx_data, prev);
  endtask

  task automatic t_overrun(logic [2:0] f, logic [8:0] a, logic [8:0] b);
    int t0;
    fmt = f; odd = 0;
    rx_frame(f, a, 0, 0, 0, t0);
    chk("R10 first word no overrun", oerr, 0);
    rx_frame(f, b, 0, 0, 0, t0);
    chk("R10 overrun flagged", oerr, 1);
    chk("R10 new word kept", rx_data, b & msk(f));
    clear_all();
    chk("R11 overrun cleared", oerr, 0);
  endtask

  task automatic t_same_cycle();
    int t0;
    fmt = 3'd2; odd = 0;
    flag_rd = 1;
    rx_frame(3'd2, 9'h0c5, 0, 0, 1, t0);
    flag_rd = 0;
    chk("R11 set beats read", ferr_at_irq, 1);
    chk("R11 read clears next cycle", ferr, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();

    t_tx(3'd2, 9'h05a, 0);
    t_tx(3'd1, 9'h035, 0);
    t_tx(3'd3, 9'h0c3, 1);
    t_tx(3'd4, 9'h1a5, 0);
    t_tx(3'd0, 9'h17f, 1);

    t_rx(3'd2, 9'h0a5, 0, 0, 0);
    t_rx(3'd0, 9'h1ab, 0, 0, 0);
    t_rx(3'd1, 9'h046, 0, 0, 0);
    t_rx(3'd1, 9'h046, 1, 1, 0);
    t_rx(3'd3, 9'h081, 0, 1, 0);
    t_rx(3'd3, 9'h081, 1, 0, 0);
    t_rx(3'd4, 9'h1c3, 0, 0, 0);
    t_rx(3'd2, 9'h03c, 0, 0, 1);
    t_rx(3'd4, 9'h0f0, 0, 0, 1);

    t_false_start();
    t_overrun(3'd2, 9'h011, 9'h0ee);
    t_overrun(3'd4, 9'h155, 9'h0aa);
    t_same_cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule